// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to 16 pins, sitting behind a simple 32-bit register bus. Software sets each pin as input or output, writes an output latch that drives the output pins, and reads back the synchronised level of every pin. Each pin can also raise an interrupt. Its trigger is programmable: rising edge, falling edge, either edge, high level or low level. Pending events are collected in a status register. They can be acknowledged one pin at a time, and a mask filters which of them reach the single combined interrupt line.

The pin inputs pass through a two-flop synchroniser. Edges are found by comparing each synchronised sample with the one before it. A status bit can only be set while the pin's enable bit is 1. For a level trigger the status bit is set again on every cycle the level is present, so acknowledging it only sticks once the level has gone. A soft-reset register returns every configuration register and every status bit to its reset value.

The bus accepts one access per cycle and never applies back-pressure, so there is no ready signal. A read request (`bus_req` with `bus_we` low) is answered one cycle later: `bus_rvalid` is high for exactly that cycle and `bus_rdata` carries the value. A write takes effect at the clock edge on which it is presented. Addresses are byte addresses of 32-bit words. Bits [1:0] of the address are ignored.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the enable, mask, output, direction, mode and status registers read 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: The output register (0x18) and the direction register (0x20) store the low NPINS bits of the write data and read back with the upper bits at 0. `pin_out` follows the output register, and `pin_oe` bit i is 1 when direction bit i is 1 (the pin is then an output).
- R3: The input register (0x1C) returns the pin levels after a two-flop synchroniser. Writes to the input register, the status register (0x04) and the display register (0x08) have no effect. The clear register (0x0C) and the reserved word (0x2C) read 0.
- R4: Trigger code 3'b001 sets a pin's status bit on a rising edge only, and code 3'b000 sets it on a falling edge only.
- R5: Trigger code 3'b100 sets the status bit on both rising and falling edges.
- R6: Code 3'b011 sets the status bit while the pin is high, and code 3'b010 sets it while the pin is low. If the level is still present, the bit is set again on the cycle after it is cleared.
- R7: A status bit is set only while that pin's enable bit (register 0x00) is 1. Pin events with the enable bit at 0 leave the status register unchanged.
- R8: Writing 1 to bit i of the clear register (0x0C) clears status bit i. Zero bits leave status unchanged. If a clear and a new event fall on the same cycle, the clear wins.
- R9: Writing 1s to the mask-set register (0x10) sets those mask bits, and writing 1s to the mask-clear register (0x14) clears them. Zero bits leave the mask unchanged, and both addresses read the mask. The display register (0x08) reads status AND NOT mask, and `irq` is the OR of those bits.
- R10: Pins 0 to 7 take their 3-bit trigger code from the mode-0 register (0x24), and pins 8 to 15 from the mode-1 register (0x28), at bits [4*(i mod 8)+2 : 4*(i mod 8)]. Bit 3 of each nibble reads 0. Codes 3'b101 to 3'b111 never set status.
- R11: While the soft-reset bit (bit 0 of 0x30) is 1, all configuration and status registers are held at their reset values. Writing 1 and then 0 therefore leaves the port in its reset state. The bit reads back as written.
- R12: Every read is answered with `bus_rvalid` high exactly one cycle after the request. A write produces no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, accepted every cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined unmasked pending interrupt |

## Verification
A wrong value held in the enable, mask or trigger state does not show by itself. It appears on the ports only when a pin event arrives: three clock edges after `pin_in` changes, as a wrong `irq` level or a wrong status read. The bench therefore drives every trigger code through both edge directions and both levels, and reads status and display after each change. Mistakes in the set/clear logic for mask and status show at the next read, because a wrong bit then differs from the expected value. A soft-reset fault shows on `pin_oe` and `irq` from the second edge after the soft-reset bit is written.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Trigger codes, 3 bits per pin
  localparam logic [2:0] TRIG_FALL = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_LOW  = 3'b010;
  localparam logic [2:0] TRIG_HIGH = 3'b011;
  localparam logic [2:0] TRIG_BOTH = 3'b100;

  localparam int TRIG_W     = 3;
  localparam int MODE_PITCH = 4;
  localparam int PINS_PER_MODE_REG = 8;

  // Word index of each register (byte address / 4); software decodes this order
  typedef enum logic [3:0] {
    REG_EN    = 4'd0,
    REG_STAT  = 4'd1,
    REG_DISP  = 4'd2,
    REG_CLR   = 4'd3,
    REG_MSET  = 4'd4,
    REG_MCLR  = 4'd5,
    REG_OUT   = 4'd6,
    REG_IN    = 4'd7,
    REG_DIR   = 4'd8,
    REG_MODE0 = 4'd9,
    REG_MODE1 = 4'd10,
    REG_RSVD  = 4'd11,
    REG_SRST  = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          lvl,
  input  logic [TRIG_W*NPINS-1:0]   mode_flat,
  output logic [NPINS-1:0]          hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [TRIG_W-1:0] code;
    logic rise, fall, hit_g;
    assign code = mode_flat[TRIG_W*g +: TRIG_W];
    assign rise = lvl[g] & ~prev_q[g];
    assign fall = ~lvl[g] & prev_q[g];
    always_comb begin
      case (code)
        TRIG_FALL: hit_g = fall;
        TRIG_RISE: hit_g = rise;
        TRIG_LOW:  hit_g = ~lvl[g];
        TRIG_HIGH: hit_g = lvl[g];
        TRIG_BOTH: hit_g = rise | fall;
        default:   hit_g = 1'b0;
      endcase
    end
    assign hit[g] = hit_g;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic [NPINS-1:0] lvl, hit, clr_bits;
  logic [NPINS-1:0] en_q, stat_q, mask_q, out_q, dir_q;
  logic             srst_q;
  logic [TRIG_W-1:0] mode_q [NPINS];
  logic [TRIG_W*NPINS-1:0] mode_flat;
  logic [31:0]      mode0_rd, mode1_rd, rd_mux;
  logic             unused_bits;

  assign idx = bus_addr[ADDR_W-1:2];
  assign wr  = bus_req & bus_we;
  assign rd  = bus_req & ~bus_we;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode_flat(mode_flat), .hit(hit)
  );

  assign clr_bits = (wr && idx == IDX_W'(REG_CLR)) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; stat_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
      srst_q <= 1'b0;
    end else begin
      if (wr && idx == IDX_W'(REG_SRST)) srst_q <= bus_wdata[0];
      if (srst_q) begin
        en_q <= '0; stat_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
      end else begin
        // clear wins over a same-cycle event
        stat_q <= (stat_q | (hit & en_q)) & ~clr_bits;
        if (wr && idx == IDX_W'(REG_EN))   en_q   <= bus_wdata[NPINS-1:0];
        if (wr && idx == IDX_W'(REG_OUT))  out_q  <= bus_wdata[NPINS-1:0];
        if (wr && idx == IDX_W'(REG_DIR))  dir_q  <= bus_wdata[NPINS-1:0];
        if (wr && idx == IDX_W'(REG_MSET)) mask_q <= mask_q | bus_wdata[NPINS-1:0];
        if (wr && idx == IDX_W'(REG_MCLR)) mask_q <= mask_q & ~bus_wdata[NPINS-1:0];
      end
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_mode
    localparam int LANE = i % PINS_PER_MODE_REG;
    localparam logic [IDX_W-1:0] MY_REG =
      (i < PINS_PER_MODE_REG) ? IDX_W'(REG_MODE0) : IDX_W'(REG_MODE1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mode_q[i] <= TRIG_FALL;
      else if (srst_q)             mode_q[i] <= TRIG_FALL;
      else if (wr && idx == MY_REG)
        mode_q[i] <= bus_wdata[MODE_PITCH*LANE +: TRIG_W];
    end
    assign mode_flat[TRIG_W*i +: TRIG_W] = mode_q[i];
  end

  always_comb begin
    mode0_rd = '0;
    mode1_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < PINS_PER_MODE_REG)
        mode0_rd[MODE_PITCH*(i % PINS_PER_MODE_REG) +: TRIG_W] = mode_q[i];
      else
        mode1_rd[MODE_PITCH*(i % PINS_PER_MODE_REG) +: TRIG_W] = mode_q[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(REG_EN):    rd_mux = 32'(en_q);
      IDX_W'(REG_STAT):  rd_mux = 32'(stat_q);
      IDX_W'(REG_DISP):  rd_mux = 32'(stat_q & ~mask_q);
      IDX_W'(REG_MSET),
      IDX_W'(REG_MCLR):  rd_mux = 32'(mask_q);
      IDX_W'(REG_OUT):   rd_mux = 32'(out_q);
      IDX_W'(REG_IN):    rd_mux = 32'(lvl);
      IDX_W'(REG_DIR):   rd_mux = 32'(dir_q);
      IDX_W'(REG_MODE0): rd_mux = mode0_rd;
      IDX_W'(REG_MODE1): rd_mux = mode1_rd;
      IDX_W'(REG_SRST):  rd_mux = {31'd0, srst_q};
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_port_checks.sv
module gpio_port_checks
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  mask_q,
  input logic              srst_q,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  localparam int IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && idx == IW'(REG_CLR))
      |=> ((stat_q & $past(bus_wdata[NPINS-1:0])) == '0));

  p_no_set_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && idx == IW'(REG_MSET) && !srst_q)
      |=> ((mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && idx == IW'(REG_MCLR) && !srst_q)
      |=> ((mask_q & $past(bus_wdata[NPINS-1:0])) == '0));

  p_srst_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (pin_oe == '0 && !irq));

  p_read_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  p_no_spurious_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

bind gpio_irq_port gpio_port_checks #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .stat_q(stat_q), .en_q(en_q), .mask_q(mask_q), .srst_q(srst_q),
  .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  localparam int NPINS  = 16;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_irq_port #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 pin_out", 32'(pin_out), 0);
    rd(6'h00, 0, "R1 enable");
    rd(6'h04, 0, "R1 status");
    rd(6'h10, 0, "R1 mask");
    rd(6'h20, 0, "R1 direction");
    rd(6'h24, 0, "R1 mode0");

    // R2 output / direction
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_A5A5);
    rd(6'h18, 32'h0000_FFFF, "R2 output readback");
    rd(6'h20, 32'h0000_A5A5, "R2 direction readback");
    check("R2 pin_out", 32'(pin_out), 32'h0000_FFFF);
    check("R2 pin_oe", 32'(pin_oe), 32'h0000_A5A5);

    // R3 input path; R7 events with enable 0
    pin_in = 16'h1234;
    idle(4);
    rd(6'h1C, 32'h1234, "R3 input");
    wr(6'h1C, 32'hFFFF);
    wr(6'h04, 32'hFFFF);
    wr(6'h08, 32'hFFFF);
    rd(6'h1C, 32'h1234, "R3 input write ignored");
    rd(6'h04, 0, "R3 status write ignored");
    rd(6'h0C, 0, "R3 clear reads zero");
    rd(6'h2C, 0, "R3 reserved reads zero");
    pin_in = 16'h0000;
    idle(4);
    rd(6'h04, 0, "R7 falling edges with enable 0");

    // R10 mode fields; bit 3 of nibbles dropped
    wr(6'h24, 32'h8052_3409);
    wr(6'h28, 32'h0000_0001);
    rd(6'h24, 32'h0052_3401, "R10 mode0 readback");
    rd(6'h28, 32'h0000_0001, "R10 mode1 readback");

    wr(6'h00, 32'h0000_013F);
    wr(6'h0C, 32'h0000_FFFF);
    idle(1);
    rd(6'h04, 32'h0010, "R6 level low reasserts");

    pin_in = 16'h010D;
    idle(4);
    rd(6'h04, 32'h011D, "R4 R5 R6 R10 events");
    rd(6'h08, 32'h011D, "R9 display unmasked");
    check("R9 irq high", 32'(irq), 1);

    wr(6'h10, 32'h0000_011D);
    rd(6'h08, 0, "R9 display all masked");
    rd(6'h10, 32'h011D, "R9 mask-set readback");
    check("R9 irq low when masked", 32'(irq), 0);
    wr(6'h14, 32'h0000_0001);
    rd(6'h14, 32'h011C, "R9 mask-clear readback");
    rd(6'h08, 32'h0001, "R9 display after unmask");
    check("R9 irq after unmask", 32'(irq), 1);

    wr(6'h0C, 32'h0000_0105);
    rd(6'h04, 32'h0018, "R8 partial clear");
    wr(6'h0C, 32'h0000_0018);
    idle(1);
    rd(6'h04, 32'h0018, "R6 level persists after clear");

    pin_in = 16'h0012;
    idle(4);
    rd(6'h04, 32'h001C, "R4 R5 wrong-edge ignored, both fires");
    wr(6'h0C, 32'h0000_FFFF);
    idle(1);
    rd(6'h04, 0, "R6 level gone, clear sticks");

    pin_in = 16'h0010;
    idle(4);
    rd(6'h04, 32'h0002, "R4 falling edge");
    pin_in = 16'h0030;
    idle(4);
    pin_in = 16'h0010;
    idle(4);
    rd(6'h04, 32'h0002, "R10 code 101 never fires");
    rd(6'h08, 32'h0002, "R9 display");
    check("R9 irq", 32'(irq), 1);

    // R11 soft reset
    wr(6'h30, 32'h1);
    rd(6'h30, 32'h1, "R11 soft-reset bit readback");
    wr(6'h30, 32'h0);
    idle(1);
    check("R11 pin_oe", 32'(pin_oe), 0);
    check("R11 pin_out", 32'(pin_out), 0);
    check("R11 irq", 32'(irq), 0);
    rd(6'h00, 0, "R11 enable");
    rd(6'h10, 0, "R11 mask");
    rd(6'h24, 0, "R11 mode0");
    rd(6'h04, 0, "R11 status");
    rd(6'h30, 0, "R11 bit cleared");

    // R12 write gives no rvalid
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h18; bus_wdata = 32'h1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check("R12 no rvalid on write", 32'(bus_rvalid), 0);
    idle(2);
    check("R12 all reads answered", 32'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule